// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status Generator

This block watches the state a hypervisor keeps for a virtual CPU interface and works out which maintenance conditions are active. It scans an array of list-register state fields, qualifies each condition with its own enable bit, and registers the result as an 8-bit status word. Software reads that word as a 64-bit value. A single maintenance interrupt line is raised whenever any status bit is set.

Two of the conditions are not simple flags. "No pending" requires a scan over every list-register entry. "Underflow" fires when no more than one entry holds a valid interrupt. The other conditions follow the virtual group enables, a non-zero end-of-interrupt count, or any set bit of the end-of-interrupt status vector. The result is recomputed on every clock with one register stage, so a change on the inputs is visible one cycle later.

The design has no state machine. The only storage is the status register, and it is reloaded from the current inputs on every cycle.

Top module: `vmaint_status`

## Requirements
- R1: While reset is asserted, and on the first read after it, `status_o` is all zero and `maint_irq_o` is 0, whatever the inputs are.
- R2: Bit 7 is 1 exactly when `en_g1_off_i` is 1 and `vgrp1_en_i` is 0. Bit 6 is 1 exactly when `en_g1_on_i` is 1 and `vgrp1_en_i` is 1.
- R3: Bit 5 is 1 exactly when `en_g0_off_i` is 1 and `vgrp0_en_i` is 0. Bit 4 is 1 exactly when `en_g0_on_i` is 1 and `vgrp0_en_i` is 1.
- R4: Entry i's state is `lr_state_i[2i+1:2i]`, encoded as 00 invalid, 01 pending, 10 active, 11 pending and active. Bit 3 is 1 exactly when `en_nopend_i` is 1 and no entry holds 01 or 11.
- R5: Bit 2 is 1 exactly when `en_notpres_i` is 1 and `eoi_count_i` is non-zero.
- R6: Bit 1 is 1 exactly when `en_under_i` is 1 and at most one entry has a non-zero state.
- R7: Bit 0 is 1 exactly when at least one bit of `eoi_vec_i` is 1. This bit has no enable.
- R8: Bits 63:8 of `status_o` are always 0.
- R9: Each bit of `status_o` reflects the inputs sampled at the previous rising clock edge. `maint_irq_o` is 1 exactly when bits 7:0 of `status_o` are not all zero.
- R10: When its enable is 0, each of bits 7 to 1 reads 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lr_state_i | input | 2*N_LR | Packed list-register state fields, entry i at bits 2i+1:2i |
| en_g1_off_i | input | 1 | Enable for the group 1 disabled condition |
| en_g1_on_i | input | 1 | Enable for the group 1 enabled condition |
| en_g0_off_i | input | 1 | Enable for the group 0 disabled condition |
| en_g0_on_i | input | 1 | Enable for the group 0 enabled condition |
| en_nopend_i | input | 1 | Enable for the no-pending condition |
| en_notpres_i | input | 1 | Enable for the entry-not-present condition |
| en_under_i | input | 1 | Enable for the underflow condition |
| eoi_count_i | input | CNT_W | End-of-interrupt count field |
| vgrp0_en_i | input | 1 | Virtual group 0 enable |
| vgrp1_en_i | input | 1 | Virtual group 1 enable |
| eoi_vec_i | input | EOI_W | End-of-interrupt status vector |
| status_o | output | 64 | Registered status word, upper 56 bits zero |
| maint_irq_o | output | 1 | Maintenance interrupt |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. The status word and the interrupt line have the same latency, because the line is decoded from the registered word. The driver changes inputs on a falling edge and queues the expected word and line for that stimulus. The monitor checks the front of the queue shortly after the next rising edge, so it compares each result against the stimulus from the cycle before it.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;

    localparam int STAT_W = 8;
    localparam int READ_W = 64;

    typedef enum logic [1:0] {
        LR_INVALID = 2'b00,
        LR_PEND    = 2'b01,
        LR_ACT     = 2'b10,
        LR_PENDACT = 2'b11
    } lr_state_e;

    // status bit positions (software decodes these)
    localparam int B_EOI    = 0;
    localparam int B_UNDER  = 1;
    localparam int B_NOTPRS = 2;
    localparam int B_NOPEND = 3;
    localparam int B_G0ON   = 4;
    localparam int B_G0OFF  = 5;
    localparam int B_G1ON   = 6;
    localparam int B_G1OFF  = 7;

    typedef struct packed {
        logic g1_off;
        logic g1_on;
        logic g0_off;
        logic g0_on;
        logic nopend;
        logic notpres;
        logic under;
    } cond_en_t;

endpackage

// File: rtl/vmaint_lr_scan.sv
module vmaint_lr_scan
    import vmaint_pkg::*;
#(
    parameter int N_LR = 4
) (
    input  logic [2*N_LR-1:0] lr_state_i,
    output logic              any_pend_o,
    output logic              le_one_valid_o
);

    logic [N_LR-1:0] valid_v;
    logic [N_LR-1:0] pend_v;

    generate
        for (genvar gi = 0; gi < N_LR; gi++) begin : g_entry
            lr_state_e st;
            assign st         = lr_state_e'(lr_state_i[2*gi +: 2]);
            assign valid_v[gi] = (st != LR_INVALID);
            assign pend_v[gi]  = (st == LR_PEND) || (st == LR_PENDACT);
        end
    endgenerate

    // two-flag reduction: "seen one valid" and "seen two valid"
    logic seen_one;
    logic seen_two;

    always_comb begin
        seen_one = 1'b0;
        seen_two = 1'b0;
        for (int i = 0; i < N_LR; i++) begin
            seen_two = seen_two | (seen_one & valid_v[i]);
            seen_one = seen_one | valid_v[i];
        end
    end

    assign any_pend_o     = |pend_v;
    assign le_one_valid_o = ~seen_two;

endmodule

// File: rtl/vmaint_cond_eval.sv
module vmaint_cond_eval
    import vmaint_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int EOI_W = 4
) (
    input  cond_en_t            en_i,
    input  logic                any_pend_i,
    input  logic                le_one_valid_i,
    input  logic [CNT_W-1:0]    eoi_count_i,
    input  logic                vgrp0_en_i,
    input  logic                vgrp1_en_i,
    input  logic [EOI_W-1:0]    eoi_vec_i,
    output logic [STAT_W-1:0]   next_o
);

    always_comb begin
        next_o           = '0;
        next_o[B_G1OFF]  = en_i.g1_off  & ~vgrp1_en_i;
        next_o[B_G1ON]   = en_i.g1_on   &  vgrp1_en_i;
        next_o[B_G0OFF]  = en_i.g0_off  & ~vgrp0_en_i;
        next_o[B_G0ON]   = en_i.g0_on   &  vgrp0_en_i;
        next_o[B_NOPEND] = en_i.nopend  & ~any_pend_i;
        next_o[B_NOTPRS] = en_i.notpres & (|eoi_count_i);
        next_o[B_UNDER]  = en_i.under   &  le_one_valid_i;
        next_o[B_EOI]    = |eoi_vec_i;
    end

endmodule

// File: rtl/vmaint_status.sv
module vmaint_status
    import vmaint_pkg::*;
#(
    parameter int N_LR  = 4,
    parameter int CNT_W = 5,
    parameter int EOI_W = N_LR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*N_LR-1:0]   lr_state_i,
    input  logic                en_g1_off_i,
    input  logic                en_g1_on_i,
    input  logic                en_g0_off_i,
    input  logic                en_g0_on_i,
    input  logic                en_nopend_i,
    input  logic                en_notpres_i,
    input  logic                en_under_i,
    input  logic [CNT_W-1:0]    eoi_count_i,
    input  logic                vgrp0_en_i,
    input  logic                vgrp1_en_i,
    input  logic [EOI_W-1:0]    eoi_vec_i,
    output logic [63:0]         status_o,
    output logic                maint_irq_o
);

    localparam int PAD_W = READ_W - STAT_W;

    cond_en_t            en;
    logic                any_pend;
    logic                le_one_valid;
    logic [STAT_W-1:0]   stat_d;
    logic [STAT_W-1:0]   stat_q;

    assign en = '{g1_off:  en_g1_off_i,
                  g1_on:   en_g1_on_i,
                  g0_off:  en_g0_off_i,
                  g0_on:   en_g0_on_i,
                  nopend:  en_nopend_i,
                  notpres: en_notpres_i,
                  under:   en_under_i};

    vmaint_lr_scan #(.N_LR(N_LR)) u_scan (
        .lr_state_i     (lr_state_i),
        .any_pend_o     (any_pend),
        .le_one_valid_o (le_one_valid)
    );

    vmaint_cond_eval #(.CNT_W(CNT_W), .EOI_W(EOI_W)) u_eval (
        .en_i           (en),
        .any_pend_i     (any_pend),
        .le_one_valid_i (le_one_valid),
        .eoi_count_i    (eoi_count_i),
        .vgrp0_en_i     (vgrp0_en_i),
        .vgrp1_en_i     (vgrp1_en_i),
        .eoi_vec_i      (eoi_vec_i),
        .next_o         (stat_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status_o    = {{PAD_W{1'b0}}, stat_q};
    assign maint_irq_o = |stat_q;

    AST_EOI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|eoi_vec_i) |=> status_o[B_EOI]); // R7

    AST_NOPEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_nopend_i && !any_pend) |=> status_o[B_NOPEND]); // R4

    AST_NOTPRS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_notpres_i && (eoi_count_i != '0)) |=> status_o[B_NOTPRS]); // R5

    AST_UNDER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_under_i |=> !status_o[B_UNDER]); // R10

    AST_IRQ_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (|eoi_vec_i) |=> maint_irq_o); // R9

endmodule

// File: tb/tb_vmaint_status.sv
module tb_vmaint_status;

    localparam int N_LR  = 4;
    localparam int CNT_W = 5;
    localparam int EOI_W = N_LR;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [2*N_LR-1:0]   lr_state_i = '0;
    logic                en_g1_off_i = 0, en_g1_on_i = 0, en_g0_off_i = 0, en_g0_on_i = 0;
    logic                en_nopend_i = 0, en_notpres_i = 0, en_under_i = 0;
    logic [CNT_W-1:0]    eoi_count_i = '0;
    logic                vgrp0_en_i = 0, vgrp1_en_i = 0;
    logic [EOI_W-1:0]    eoi_vec_i = '0;
    logic [63:0]         status_o;
    logic                maint_irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    vmaint_status #(.N_LR(N_LR), .CNT_W(CNT_W), .EOI_W(EOI_W)) dut (
        .clk(clk), .rst_n(rst_n), .lr_state_i(lr_state_i),
        .en_g1_off_i(en_g1_off_i), .en_g1_on_i(en_g1_on_i),
        .en_g0_off_i(en_g0_off_i), .en_g0_on_i(en_g0_on_i),
        .en_nopend_i(en_nopend_i), .en_notpres_i(en_notpres_i),
        .en_under_i(en_under_i), .eoi_count_i(eoi_count_i),
        .vgrp0_en_i(vgrp0_en_i), .vgrp1_en_i(vgrp1_en_i),
        .eoi_vec_i(eoi_vec_i), .status_o(status_o), .maint_irq_o(maint_irq_o)
    );

    typedef struct {
        logic [63:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // independent model of the requirements
    function automatic logic [7:0] model(input logic [6:0] en, input logic [2*N_LR-1:0] lr,
                                         input logic [CNT_W-1:0] cnt, input logic g0, input logic g1,
                                         input logic [EOI_W-1:0] ev);
        logic [7:0] m;
        int nvalid;
        bit pend;
        nvalid = 0;
        pend = 0;
        for (int i = 0; i < N_LR; i++) begin
            if (lr[2*i +: 2] != 2'b00) nvalid++;
            if (lr[2*i +: 2] == 2'b01 || lr[2*i +: 2] == 2'b11) pend = 1;
        end
        m[7] = en[6] && !g1;
        m[6] = en[5] && g1;
        m[5] = en[4] && !g0;
        m[4] = en[3] && g0;
        m[3] = en[2] && !pend;
        m[2] = en[1] && (cnt != 0);
        m[1] = en[0] && (nvalid <= 1);
        m[0] = (ev != 0);
        return m;
    endfunction

    // en: [6]g1off [5]g1on [4]g0off [3]g0on [2]nopend [1]notpres [0]under
    task automatic apply(input logic [6:0] en, input logic [2*N_LR-1:0] lr,
                         input logic [CNT_W-1:0] cnt, input logic g0, input logic g1,
                         input logic [EOI_W-1:0] ev, input string tag);
        exp_t e;
        logic [7:0] m;
        @(negedge clk);
        {en_g1_off_i, en_g1_on_i, en_g0_off_i, en_g0_on_i,
         en_nopend_i, en_notpres_i, en_under_i} = en;
        lr_state_i = lr; eoi_count_i = cnt; vgrp0_en_i = g0; vgrp1_en_i = g1; eoi_vec_i = ev;
        m = model(en, lr, cnt, g0, g1, ev);
        e.st = {56'b0, m};     // R8 upper bits zero
        e.irq = (m != 0);      // R9
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: result due one rising edge after the stimulus
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (status_o !== e.st || maint_irq_o !== e.irq) begin
                n_bad++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         e.tag, status_o, maint_irq_o, e.st, e.irq);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds zero even with triggering inputs
        {en_g1_off_i, en_g1_on_i, en_g0_off_i, en_g0_on_i,
         en_nopend_i, en_notpres_i, en_under_i} = 7'h7F;
        eoi_vec_i = '1; eoi_count_i = 5'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (status_o !== 64'h0 || maint_irq_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: status=%h irq=%b expected status=0 irq=0", status_o, maint_irq_o);
        end
        rst_n = 1'b1;

        apply(7'h00, 8'h00, 5'd0, 0, 0, 4'h0, "R10 all enables off");
        apply(7'b1000000, 8'h00, 5'd0, 0, 0, 4'h0, "R2 group1 off flagged");
        apply(7'b1100000, 8'h00, 5'd0, 0, 1, 4'h0, "R2 group1 on flagged");
        apply(7'b0011000, 8'h00, 5'd0, 0, 0, 4'h0, "R3 group0 off flagged");
        apply(7'b0011000, 8'h00, 5'd0, 1, 0, 4'h0, "R3 group0 on flagged");
        apply(7'b0000100, 8'h00, 5'd0, 0, 0, 4'h0, "R4 no entries pending");
        apply(7'b0000100, 8'b00_00_01_00, 5'd0, 0, 0, 4'h0, "R4 state 01 pending");
        apply(7'b0000100, 8'b11_00_00_00, 5'd0, 0, 0, 4'h0, "R4 state 11 pending");
        apply(7'b0000100, 8'b10_10_10_10, 5'd0, 0, 0, 4'h0, "R4 only active entries");
        apply(7'b0000010, 8'h00, 5'd0, 0, 0, 4'h0, "R5 count zero");
        apply(7'b0000010, 8'h00, 5'd1, 0, 0, 4'h0, "R5 count one");
        apply(7'b0000010, 8'h00, 5'd31, 0, 0, 4'h0, "R5 count max");
        apply(7'b0000001, 8'h00, 5'd0, 0, 0, 4'h0, "R6 zero valid");
        apply(7'b0000001, 8'b00_10_00_00, 5'd0, 0, 0, 4'h0, "R6 one valid");
        apply(7'b0000001, 8'b01_00_00_10, 5'd0, 0, 0, 4'h0, "R6 two valid");
        apply(7'b0000001, 8'b11_11_11_11, 5'd0, 0, 0, 4'h0, "R6 all valid");
        apply(7'h00, 8'h00, 5'd0, 0, 0, 4'b1000, "R7 single eoi bit");
        apply(7'h00, 8'h00, 5'd0, 0, 0, 4'b0001, "R7 low eoi bit");
        apply(7'h00, 8'h00, 5'd9, 1, 0, 4'h0, "R10 triggers but masked");
        apply(7'h7F, 8'b00_00_00_10, 5'd4, 1, 1, 4'hF, "R9 R8 many bits set");
        apply(7'h7F, 8'b01_01_01_01, 5'd0, 0, 1, 4'h0, "R9 mixed pattern");
        apply(7'h00, 8'h00, 5'd0, 0, 0, 4'h0, "R9 irq clears");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule